// File: doc/BRIEF.md
# Prioritised Interrupt Level Concentrator

The block gathers thirteen level-sensitive interrupt lines from board peripherals and turns them into one 4-bit encoded request level for the CPU. Each line has a fixed position in a 16-bit status word and a fixed priority level. A software-written enable word selects which positions may take part. Among the lines that are asserted and enabled, the one with the numerically smallest level wins. The output carries that level inverted in all four bits, so a quiet board drives 0.

A small 16-bit register port sits beside the request logic. Software uses it to set the enable word, read and write a general-purpose output latch, read a fixed version code, and request power-off. A power-off write starts a short state sequence. The sequence has two states: `PW_IDLE` and `PW_FIRE`. A qualifying write moves `PW_IDLE` to `PW_FIRE`. `PW_FIRE` returns to `PW_IDLE` when no new qualifying write arrives, and stays in `PW_FIRE` if another one does. The shutdown output is high exactly while the state is `PW_FIRE`.

Source index (port bit of `src_i`) to status bit and level: 0→bit 15/level 12 (touch panel), 1→14/9 (PCI A), 2→13/10 (PCI B), 3→12/3 (PCI C), 4→11/0 (PCI D), 5→10/4 (video), 6→9/1 (storage IDE), 7→8/2 (storage card-detect), 8→7/8 (SD card), 9→6/5 (keypad), 10→5/6 (RTC alarm), 11→4/7 (RTC tick), 12→0/11 (external). Status bits 1 to 3 have no source.

Top module: `irqc_top`

## Requirements
- R1: Each source index i drives the status bit and has the level given in the table above; with only that source asserted and its bit enabled, `irl_o` equals its level XOR 15.
- R2: Sources are level-sensitive: once a source deasserts, its request is gone after the next clock edge, and nothing is remembered.
- R3: A source whose status bit is 0 in the enable word has no effect on `irl_o`, whatever its line does.
- R4: When no source is both asserted and enabled, `irl_o` is 0.
- R5: With several candidates, the smallest level wins, and `irl_o` = level XOR 15 (level 0 gives 15).
- R6: The enable word sits at byte offset 0x00, reads back what was written, and a write to it affects `irl_o` from the next clock edge, together with any source change in the same cycle.
- R7: The output latch sits at offset 0x36, reads back what was written, and drives `gpo_o` from the next clock edge.
- R8: A write to offset 0x30 with data bit 0 set raises `shdn_o` for one cycle after the write edge. A write there with bit 0 clear does nothing. A read of 0x30 returns 0.
- R9: Offset 0x32 always reads 0x0010, and writes to it change no register.
- R10: Any other offset reads 0, and a write to it changes no register.
- R11: After reset the enable word and the latch are 0, and `irl_o` and `shdn_o` are 0.
- R12: `irl_o` is registered: a source change made between edges shows only after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | 13 | Peripheral interrupt lines, active high, level-sensitive |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 6 | Byte offset within the 64-byte window |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i`, combinational |
| irl_o | output | 4 | Encoded request level, inverted, 0 when idle |
| gpo_o | output | 16 | General-purpose output latch |
| shdn_o | output | 1 | Shutdown request pulse |

## Verification
A write to the enable word and a change of the source lines can fall in the same cycle. The priority logic has to use both the new enable word and the new lines. The bench changes `src_i` and issues an enable write at the same falling edge. It then compares `irl_o` after the next rising edge with the value its own table computes from the new pair. It also drops the winning source and turns on a lower-priority one in one cycle, and checks that the request moves straight to the new winner.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int SRC_N  = 13;
    localparam int WORD_W = 16;
    localparam int LVL_W  = 4;
    localparam int ADDR_W = 6;
    localparam int LVL_NONE = (1 << LVL_W) - 1;

    localparam logic [ADDR_W-1:0] OFF_ENABLE  = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_POWER   = 6'h30;
    localparam logic [ADDR_W-1:0] OFF_VERSION = 6'h32;
    localparam logic [ADDR_W-1:0] OFF_LATCH   = 6'h36;
    localparam logic [WORD_W-1:0] VERSION_CODE = 16'h0010;

    typedef enum logic [0:0] { PW_IDLE = 1'b0, PW_FIRE = 1'b1 } pw_state_e;

    // status bit taken by each source index
    function automatic int src_bit(input int i);
        case (i)
            0: return 15;  1: return 14;  2: return 13;  3: return 12;
            4: return 11;  5: return 10;  6: return 9;   7: return 8;
            8: return 7;   9: return 6;   10: return 5;  11: return 4;
            default: return 0;
        endcase
    endfunction

    // fixed priority level of each source index
    function automatic int src_lvl(input int i);
        case (i)
            0: return 12;  1: return 9;   2: return 10;  3: return 3;
            4: return 0;   5: return 4;   6: return 1;   7: return 2;
            8: return 8;   9: return 5;   10: return 6;  11: return 7;
            default: return 11;
        endcase
    endfunction

    // level owned by a status bit, LVL_NONE for bits without a source
    function automatic int bit_lvl(input int b);
        for (int i = 0; i < SRC_N; i++) begin
            if (src_bit(i) == b) return src_lvl(i);
        end
        return LVL_NONE;
    endfunction
endpackage

// File: rtl/irqc_srcmap.sv
module irqc_srcmap
    import irqc_pkg::*;
(
    input  logic [SRC_N-1:0]  src_i,
    output logic [WORD_W-1:0] word_o
);
    always_comb begin
        word_o = '0;
        for (int i = 0; i < SRC_N; i++) begin
            word_o[src_bit(i)] = src_i[i];
        end
    end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
(
    input  logic [WORD_W-1:0] cand_i,
    output logic [LVL_W-1:0]  code_o
);
    logic [LVL_W-1:0] best;

    always_comb begin
        best = LVL_W'(LVL_NONE);
        for (int b = 0; b < WORD_W; b++) begin
            if (cand_i[b] && (LVL_W'(bit_lvl(b)) < best)) begin
                best = LVL_W'(bit_lvl(b));
            end
        end
        code_o = best ^ LVL_W'(LVL_NONE);
    end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic [WORD_W-1:0] enable_q_o,
    output logic [WORD_W-1:0] enable_d_o,
    output logic [WORD_W-1:0] latch_o,
    output logic              shdn_o
);
    logic [WORD_W-1:0] enable_q, latch_q;
    pw_state_e         pw_q, pw_d;
    logic              pw_req;

    assign pw_req     = wr_i && (addr_i == OFF_POWER) && wdata_i[0];
    assign enable_d_o = (wr_i && addr_i == OFF_ENABLE) ? wdata_i : enable_q;
    assign enable_q_o = enable_q;
    assign latch_o    = latch_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            enable_q <= '0;
            latch_q  <= '0;
        end else begin
            enable_q <= enable_d_o;
            if (wr_i && addr_i == OFF_LATCH) latch_q <= wdata_i;
        end
    end

    // power-off sequence: state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) pw_q <= PW_IDLE;
        else         pw_q <= pw_d;
    end

    // power-off sequence: next state
    always_comb begin
        pw_d = pw_q;
        unique case (pw_q)
            PW_IDLE: if (pw_req) pw_d = PW_FIRE;
            PW_FIRE: if (!pw_req) pw_d = PW_IDLE;
            default: pw_d = PW_IDLE;
        endcase
    end

    // power-off sequence: outputs
    always_comb begin
        shdn_o = (pw_q == PW_FIRE);
    end

    always_comb begin
        case (addr_i)
            OFF_ENABLE:  rdata_o = enable_q;
            OFF_LATCH:   rdata_o = latch_q;
            OFF_VERSION: rdata_o = VERSION_CODE;
            OFF_POWER:   rdata_o = '0;
            default:     rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [SRC_N-1:0]  src_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    output logic [WORD_W-1:0] bus_rdata_o,
    output logic [LVL_W-1:0]  irl_o,
    output logic [WORD_W-1:0] gpo_o,
    output logic              shdn_o
);
    logic [WORD_W-1:0] status_w, enable_q, enable_d;
    logic [LVL_W-1:0]  code_w, irl_q;

    irqc_srcmap u_map (
        .src_i  (src_i),
        .word_o (status_w)
    );

    irqc_regs u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .rdata_o    (bus_rdata_o),
        .enable_q_o (enable_q),
        .enable_d_o (enable_d),
        .latch_o    (gpo_o),
        .shdn_o     (shdn_o)
    );

    irqc_prio u_prio (
        .cand_i (status_w & enable_d),
        .code_o (code_w)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni) irl_q <= '0;
        else         irl_q <= code_w;
    end

    assign irl_o = irl_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic [SRC_N-1:0]  src_i,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [WORD_W-1:0] bus_wdata_i,
    input logic [WORD_W-1:0] bus_rdata_o,
    input logic [LVL_W-1:0]  irl_o,
    input logic              shdn_o,
    input logic [WORD_W-1:0] enable_q
);
    logic pw_wr;
    assign pw_wr = bus_wr_i && bus_addr_i == OFF_POWER && bus_wdata_i[0];

    a_r4_idle_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == OFF_ENABLE && bus_wdata_i == '0) |=> (irl_o == '0));

    a_r5_top_level_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_i[4] && enable_q[11] && !(bus_wr_i && bus_addr_i == OFF_ENABLE))
        |=> (irl_o == 4'hF));

    a_r8_pulse_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pw_wr |=> shdn_o);

    a_r8_quiet_otherwise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pw_wr |=> !shdn_o);

    a_r9_version_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i == OFF_VERSION) |-> (bus_rdata_o == VERSION_CODE));

    a_r10_undecoded_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i != OFF_ENABLE && bus_addr_i != OFF_LATCH && bus_addr_i != OFF_VERSION)
        |-> (bus_rdata_o == '0));
endmodule

bind irqc_top irqc_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (src_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irl_o       (irl_o),
    .shdn_o      (shdn_o),
    .enable_q    (enable_q)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] src = '0;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata, gpo;
    logic [3:0]  irl;
    logic        shdn;
    int checks = 0;
    int errors = 0;

    int lvl_tab [13] = '{12, 9, 10, 3, 0, 4, 1, 2, 8, 5, 6, 7, 11};
    int bit_tab [13] = '{15, 14, 13, 12, 11, 10, 9, 8, 7, 6, 5, 4, 0};

    always #5 clk = ~clk;

    irqc_top dut (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irl_o(irl), .gpo_o(gpo), .shdn_o(shdn)
    );

    function automatic logic [3:0] model(input logic [12:0] s, input logic [15:0] m);
        int best = 15;
        for (int i = 0; i < 13; i++) begin
            if (s[i] && m[bit_tab[i]] && lvl_tab[i] < best) best = lvl_tab[i];
        end
        return 4'(best) ^ 4'hF;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic set_src(input logic [12:0] s);
        @(negedge clk);
        src = s;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        chk("R11 irl", 16'(irl), 16'h0);
        chk("R11 shdn", 16'(shdn), 16'h0);
        chk("R11 gpo", gpo, 16'h0);
        bus_read(6'h00, d);
        chk("R11 enable", d, 16'h0);
    endtask

    task automatic t_single;
        bus_write(6'h00, 16'hFFFF);
        for (int i = 0; i < 13; i++) begin
            set_src(13'(1) << i);
            chk($sformatf("R1 source %0d", i), 16'(irl), 16'(4'(lvl_tab[i]) ^ 4'hF));
        end
        set_src('0);
    endtask

    task automatic t_mask;
        for (int i = 0; i < 13; i++) begin
            bus_write(6'h00, 16'(1) << bit_tab[i]);
            set_src(13'h1FFF);
            chk($sformatf("R1 only bit of %0d", i), 16'(irl), 16'(4'(lvl_tab[i]) ^ 4'hF));
            bus_write(6'h00, ~(16'(1) << bit_tab[i]));
            set_src(13'(1) << i);
            chk($sformatf("R3 masked %0d", i), 16'(irl), 16'h0);
        end
        set_src('0);
    endtask

    task automatic t_priority;
        logic [12:0] pats [6] = '{13'h1FFF, 13'h0AAA, 13'h1248, 13'h0011, 13'h1801, 13'h1000};
        bus_write(6'h00, 16'hFFFF);
        for (int p = 0; p < 6; p++) begin
            set_src(pats[p]);
            chk($sformatf("R5 pattern %h", pats[p]), 16'(irl), 16'(model(pats[p], 16'hFFFF)));
        end
        set_src(13'h0010);
        chk("R5 level 0 gives 15", 16'(irl), 16'hF);
        set_src('0);
    endtask

    task automatic t_level_timing;
        bus_write(6'h00, 16'hFFFF);
        @(negedge clk);
        src = 13'h0040;
        #1 chk("R12 not before edge", 16'(irl), 16'h0);
        @(negedge clk);
        chk("R12 after edge", 16'(irl), 16'hE);
        set_src('0);
        chk("R2 deassert clears", 16'(irl), 16'h0);
    endtask

    task automatic t_none;
        bus_write(6'h00, 16'h0000);
        set_src(13'h1FFF);
        chk("R4 all masked", 16'(irl), 16'h0);
        bus_write(6'h00, 16'h000E);
        chk("R4 sourceless bits", 16'(irl), 16'h0);
        set_src('0);
    endtask

    task automatic t_regs;
        logic [15:0] d;
        bus_write(6'h00, 16'hA5C3);
        bus_read(6'h00, d);
        chk("R6 enable readback", d, 16'hA5C3);
        bus_write(6'h36, 16'h1234);
        chk("R7 gpo", gpo, 16'h1234);
        bus_read(6'h36, d);
        chk("R7 latch readback", d, 16'h1234);
        bus_read(6'h32, d);
        chk("R9 version", d, 16'h0010);
        bus_write(6'h32, 16'hFFFF);
        bus_read(6'h32, d);
        chk("R9 version after write", d, 16'h0010);
        bus_read(6'h00, d);
        chk("R9 enable untouched", d, 16'hA5C3);
        chk("R9 gpo untouched", gpo, 16'h1234);
        bus_write(6'h10, 16'h5555);
        bus_write(6'h37, 16'h5555);
        bus_read(6'h00, d);
        chk("R10 enable untouched", d, 16'hA5C3);
        chk("R10 gpo untouched", gpo, 16'h1234);
        bus_read(6'h02, d);  chk("R10 offset 02", d, 16'h0);
        bus_read(6'h3E, d);  chk("R10 offset 3E", d, 16'h0);
        bus_read(6'h37, d);  chk("R10 offset 37", d, 16'h0);
    endtask

    task automatic t_power;
        logic [15:0] d;
        chk("R8 idle", 16'(shdn), 16'h0);
        bus_write(6'h30, 16'h0001);
        chk("R8 pulse high", 16'(shdn), 16'h1);
        @(negedge clk);
        chk("R8 pulse one cycle", 16'(shdn), 16'h0);
        bus_write(6'h30, 16'hFFFE);
        chk("R8 bit0 clear", 16'(shdn), 16'h0);
        bus_read(6'h30, d);
        chk("R8 read zero", d, 16'h0);
    endtask

    task automatic t_same_cycle;
        bus_write(6'h00, 16'h0000);
        set_src(13'h0001);
        @(negedge clk);
        src = 13'h0A40; wr = 1'b1; addr = 6'h00; wdata = 16'h4200;
        @(negedge clk);
        wr = 1'b0;
        chk("R6 same-cycle mask and source", 16'(irl), 16'(model(13'h0A40, 16'h4200)));
        bus_write(6'h00, 16'hFFFF);
        chk("R5 winner before swap", 16'(irl), 16'(model(13'h0A40, 16'hFFFF)));
        set_src(13'h0001);
        chk("R2 swap to lower priority", 16'(irl), 16'(model(13'h0001, 16'hFFFF)));
        set_src('0);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_mask();
        t_priority();
        t_level_timing();
        t_none();
        t_regs();
        t_power();
        t_same_cycle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule